// File: doc/BRIEF.md
# Flash Command Sequencer with Boot Lockout

This block is the command front end and operation controller of a byte-wide flash memory model. It watches a chip-enable, write-enable and output-enable bus. Reads work like a plain ROM. A write to the array only happens after a multi-cycle unlock sequence. A byte program takes four write cycles and can only clear bits. A chip erase takes six write cycles and returns bytes to 0xFF.

Both operations are timed by an internal counter on the block's clock. While an operation runs, the block ignores further writes. Any read during that time returns a polling byte instead of array data, so software can tell when the operation has finished. A separate six-cycle code sets a one-time lockout flag. Once the flag is set, the 16K-byte boot window at the bottom of the address space is protected from both program and erase. The flag can only be cleared by reset.

The array is a small behavioural store. Address bits above the boot window are folded onto a compact window. Command decoding and lockout always use the full address.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: With ce_n=0, oe_n=0 and we_n=1, dq_oe is 1 and dq_o shows the byte stored at addr. After reset every byte reads 0xFF and lock_on is 0.
- R2: dq_oe is 0 whenever ce_n is 1, oe_n is 1 or we_n is 0.
- R3: A write cycle spans the time both ce_n and we_n are low. The address is taken when the later of the two falls. The data is taken when the earlier of the two rises. Later changes on addr or dq_i have no effect on that cycle.
- R4: The write sequence 0xAA at 0x5555, 0x55 at 0x2AAA, 0xA0 at 0x5555, then data D at address A programs A to old AND D. Command addresses are matched on addr[14:0] only.
- R5: A program keeps the block busy for exactly PROG_CYC clock cycles. Busy starts on the second clock edge after the write strobe ends. The array byte changes on the edge that ends busy.
- R6: The write sequence 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x10 at 0x5555 starts a chip erase. The erase lasts ERASE_CYC cycles and then sets every unprotected byte to 0xFF.
- R7: While busy, any enabled read returns {~D[7], 7'b0} for a program of data D, and 0x00 for an erase. After completion, reads return stored data again.
- R8: Write cycles that arrive while busy are ignored. They neither change the array nor start a command.
- R9: A write that does not match the next expected step of a sequence returns the decoder to idle, and the array is unchanged. A later correct sequence works normally.
- R10: The code 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x40 at 0x5555 sets lock_on with no busy period. lock_on never falls before the next reset.
- R11: With lock_on set, a program aimed at 0x00000–0x03FFF is dropped without a busy period. A chip erase leaves that window intact.
- R12: The array holds 1024 bytes. Array index = {addr >= 0x4000, addr[8:0]}, so addresses that share this index read and write the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 20 | Byte address |
| dq_i | input | 8 | Write data from the bus |
| dq_o | output | 8 | Read data or polling byte |
| dq_oe | output | 1 | Data output drive enable; 0 stands for high impedance |
| lock_on | output | 1 | Boot window lockout flag |

## Verification
A decoder left in a wrong state shows up in one of two ways. Either the next command byte fails to start a busy period, or a stray write programs a byte; both appear on the first read after the expected completion. A wrong timer value makes the polling byte last one cycle too long or too short, which is visible on a read held across the end of the operation. A lockout flag that is lost or set falsely changes the boot window after the next program or erase. The bench compares every read against a behavioural model on every clock, so each of these faults is caught within the cycle in which it becomes visible.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W    = 20,
  parameter int MEM_AW    = 10,
  parameter int BOOT_AW   = 14,
  parameter int PROG_CYC  = 10,
  parameter int ERASE_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  output logic              lock_on
);
  localparam int MEM_WORDS = 1 << MEM_AW;
  localparam int CNT_W     = $clog2(ERASE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3} st_t;

  logic              ce_q, we_q, wr, wr_d, wr_end;
  logic [ADDR_W-1:0] addr_q, a_lat;
  logic [7:0]        dq_q;
  st_t               state;
  logic              busy, op_erase, cnt_zero;
  logic [CNT_W-1:0]  cnt;
  logic [MEM_AW-1:0] op_idx, rd_idx, wr_idx;
  logic [7:0]        op_data;
  logic [7:0]        mem [MEM_WORDS];
  logic              hit_5555, hit_2aaa, a_boot;

  assign wr     = !ce_q && !we_q;
  assign wr_end = wr_d && !wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
      addr_q <= '0;
      dq_q   <= '0;
      wr_d   <= 1'b0;
      a_lat  <= '0;
    end else begin
      ce_q   <= ce_n;
      we_q   <= we_n;
      addr_q <= addr;
      dq_q   <= dq_i;
      wr_d   <= wr;
      if (wr && !wr_d) a_lat <= addr_q;
    end
  end

  assign hit_5555 = (a_lat[14:0] == 15'h5555);
  assign hit_2aaa = (a_lat[14:0] == 15'h2AAA);
  assign a_boot   = (a_lat[ADDR_W-1:BOOT_AW] == '0);
  assign wr_idx   = {!a_boot, a_lat[MEM_AW-2:0]};
  assign rd_idx   = {(addr[ADDR_W-1:BOOT_AW] != '0), addr[MEM_AW-2:0]};
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      busy     <= 1'b0;
      op_erase <= 1'b0;
      op_idx   <= '0;
      op_data  <= '0;
      cnt      <= '0;
      lock_on  <= 1'b0;
    end else if (busy) begin
      if (cnt_zero) busy <= 1'b0;
      else          cnt  <= cnt - 1'b1;
    end else if (wr_end) begin
      state <= S_IDLE;
      case (state)
        S_IDLE: if (hit_5555 && dq_q == 8'hAA) state <= S_U1;
        S_U1:   if (hit_2aaa && dq_q == 8'h55) state <= S_U2;
        S_U2:   if (hit_5555 && dq_q == 8'hA0) state <= S_PGM;
                else if (hit_5555 && dq_q == 8'h80) state <= S_E1;
        S_PGM:  if (!(lock_on && a_boot)) begin
                  busy     <= 1'b1;
                  op_erase <= 1'b0;
                  op_idx   <= wr_idx;
                  op_data  <= dq_q;
                  cnt      <= CNT_W'(PROG_CYC - 1);
                end
        S_E1:   if (hit_5555 && dq_q == 8'hAA) state <= S_E2;
        S_E2:   if (hit_2aaa && dq_q == 8'h55) state <= S_E3;
        S_E3:   if (hit_5555 && dq_q == 8'h10) begin
                  busy     <= 1'b1;
                  op_erase <= 1'b1;
                  op_data  <= 8'hFF;
                  cnt      <= CNT_W'(ERASE_CYC - 1);
                end else if (hit_5555 && dq_q == 8'h40) begin
                  lock_on <= 1'b1;
                end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= 8'hFF;
    end else if (busy && cnt_zero) begin
      if (op_erase) begin
        for (int i = 0; i < MEM_WORDS; i++)
          if (!lock_on || i >= MEM_WORDS / 2) mem[i] <= 8'hFF;
      end else begin
        mem[op_idx] <= mem[op_idx] & op_data;
      end
    end
  end

  assign dq_oe = !ce_n && !oe_n && we_n;
  assign dq_o  = !busy    ? mem[rd_idx] :
                 op_erase ? 8'h00       : {~op_data[7], 7'b0};
endmodule

module flash_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lock_on,
  input logic       busy,
  input logic       cnt_zero,
  input logic       wr,
  input logic       wr_d,
  input logic       op_erase,
  input logic [7:0] op_data,
  input logic [7:0] dq_o,
  input logic       dq_oe
);
  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(lock_on));
  assert_busy_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_d && !wr));
  assert_busy_ends_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt_zero));
  assert_erase_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_erase && dq_oe) |-> dq_o == 8'h00);
  assert_op_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_erase) && $stable(op_data)));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lock_on(lock_on), .busy(busy), .cnt_zero(cnt_zero),
  .wr(wr), .wr_d(wr_d), .op_erase(op_erase), .op_data(op_data),
  .dq_o(dq_o), .dq_oe(dq_oe)
);

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/100ps
module flash_cmd_ctrl_tb;
  localparam int PROG_CYC  = 10;
  localparam int ERASE_CYC = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [19:0] addr = '0;
  logic [7:0]  dq_i = '0;
  logic [7:0]  dq_o;
  logic        dq_oe, lock_on;

  int checks = 0, fails = 0;
  logic [7:0]  mm [1024];
  logic        m_lock = 1'b0, m_erase = 1'b0, start_req = 1'b0, live = 1'b0;
  int          m_left = 0, m_dur = 0, m_pidx = 0;
  logic [7:0]  m_pd = '0;
  logic [19:0] qa[$];
  logic [7:0]  qd[$];

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .lock_on(lock_on));

  function automatic int idx(logic [19:0] a);
    return ((a >= 20'h04000) ? 512 : 0) + int'(a & 20'h001FF);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit lo(logic [19:0] a, logic [14:0] v);
    return a[14:0] == v;
  endfunction

  task automatic model_write(logic [19:0] a, logic [7:0] d);
    int n;
    bit ok;
    if (m_left > 0 || start_req) return;
    qa.push_back(a); qd.push_back(d);
    n = qa.size();
    ok = 1;
    case (n)
      1: ok = lo(a, 15'h5555) && d == 8'hAA;
      2: ok = lo(a, 15'h2AAA) && d == 8'h55;
      3: ok = lo(a, 15'h5555) && (d == 8'hA0 || d == 8'h80);
      4: if (qd[2] == 8'hA0) begin
           if (!(m_lock && a < 20'h04000)) begin
             m_erase = 0; m_pidx = idx(a); m_pd = d; m_dur = PROG_CYC; start_req = 1;
           end
           ok = 0;
         end else ok = lo(a, 15'h5555) && d == 8'hAA;
      5: ok = lo(a, 15'h2AAA) && d == 8'h55;
      default: begin
        if (lo(a, 15'h5555) && d == 8'h10) begin
          m_erase = 1; m_dur = ERASE_CYC; start_req = 1;
        end else if (lo(a, 15'h5555) && d == 8'h40) m_lock = 1;
        ok = 0;
      end
    endcase
    if (!ok) begin qa.delete(); qd.delete(); end
  endtask

  always @(negedge clk) begin
    #1;
    if (live) begin
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          if (m_erase) begin
            for (int i = 0; i < 1024; i++) if (!m_lock || i >= 512) mm[i] = 8'hFF;
          end else mm[m_pidx] = mm[m_pidx] & m_pd;
        end
      end
      if (start_req) begin m_left = m_dur; start_req = 0; end
      chk("R10 lock_on", {7'b0, lock_on}, {7'b0, m_lock});
      if (!(!ce_n && !oe_n && we_n)) chk("R2 dq_oe", {7'b0, dq_oe}, 8'h00);
      else begin
        chk("R1 dq_oe", {7'b0, dq_oe}, 8'h01);
        if (m_left > 0) chk("R7 poll", dq_o, m_erase ? 8'h00 : {~m_pd[7], 7'b0});
        else            chk("R1 data", dq_o, mm[idx(addr)]);
      end
    end
  end

  task automatic bus_write(logic [19:0] a, logic [7:0] d, bit ce_last = 0, bit scr = 0);
    @(negedge clk); addr = a; dq_i = d; oe_n = 1;
    if (ce_last) we_n = 0; else ce_n = 0;
    @(negedge clk);
    if (ce_last) ce_n = 0; else we_n = 0;
    @(negedge clk);
    @(negedge clk); if (scr) addr = a ^ 20'h00F0F;
    @(negedge clk); if (ce_last) ce_n = 1; else we_n = 1;
    @(negedge clk); ce_n = 1; we_n = 1; if (scr) dq_i = ~d;
    @(posedge clk); model_write(a, d);
  endtask

  task automatic do_prog(logic [19:0] a, logic [7:0] d, bit cl = 0, bit scr = 0);
    bus_write(20'h05555, 8'hAA, cl, scr);
    bus_write(20'h02AAA, 8'h55, cl, scr);
    bus_write(20'h05555, 8'hA0, cl, scr);
    bus_write(a, d, cl, scr);
  endtask

  task automatic do_six(logic [7:0] last);
    bus_write(20'h05555, 8'hAA); bus_write(20'h02AAA, 8'h55);
    bus_write(20'h05555, 8'h80); bus_write(20'h05555, 8'hAA);
    bus_write(20'h02AAA, 8'h55); bus_write(20'h05555, last);
  endtask

  task automatic rd_check(logic [19:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    #2 chk(tag, dq_o, exp);
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic do_reset;
    live = 0; rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1;
    for (int i = 0; i < 1024; i++) mm[i] = 8'hFF;
    m_lock = 0; m_left = 0; start_req = 0; qa.delete(); qd.delete();
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    do_reset();
    @(negedge clk); #1;
    chk("R1 reset lock", {7'b0, lock_on}, 8'h00);
    chk("R2 reset oe", {7'b0, dq_oe}, 8'h00);
    rd_check(20'h12345, 8'hFF, "R1 erased after reset");

    do_prog(20'h80010, 8'h3C);
    @(negedge clk); addr = 20'h80010; ce_n = 0; oe_n = 0; we_n = 1;
    n = 0;
    forever begin
      #2;
      if (dq_o == 8'h80) n++; else break;
      @(negedge clk);
    end
    chk("R5 busy length", 8'(n), 8'(PROG_CYC));
    chk("R4 programmed", dq_o, 8'h3C);
    @(negedge clk); ce_n = 1; oe_n = 1;

    do_prog(20'h80010, 8'hF5, 1, 1);
    repeat (PROG_CYC + 3) @(negedge clk);
    rd_check(20'h80010, 8'h34, "R4 AND of old and new");
    rd_check(20'h80F1F, 8'hFF, "R3 late address change ignored");

    do_prog(20'h80021, 8'h81);
    rd_check(20'h00000, 8'h00, "R7 poll bit7 complement");
    repeat (PROG_CYC + 3) @(negedge clk);
    rd_check(20'h80021, 8'h81, "R7 true data after done");

    bus_write(20'h8D555, 8'hAA); bus_write(20'hAAAAA, 8'h55);
    bus_write(20'h0D555, 8'hA0); bus_write(20'h80022, 8'h0F);
    repeat (PROG_CYC + 3) @(negedge clk);
    rd_check(20'h80022, 8'h0F, "R4 low address bits decode");

    bus_write(20'h05555, 8'hAA); bus_write(20'h02AAA, 8'h55);
    bus_write(20'h05555, 8'h33); bus_write(20'h80030, 8'h00);
    repeat (PROG_CYC + 3) @(negedge clk);
    rd_check(20'h80030, 8'hFF, "R9 bad command byte");
    bus_write(20'h05555, 8'hAA); bus_write(20'h01234, 8'h55);
    bus_write(20'h05555, 8'hA0); bus_write(20'h80031, 8'h00);
    repeat (PROG_CYC + 3) @(negedge clk);
    rd_check(20'h80031, 8'hFF, "R9 bad unlock address");
    do_prog(20'h80030, 8'h55);
    repeat (PROG_CYC + 3) @(negedge clk);
    rd_check(20'h80030, 8'h55, "R9 recovery");

    do_prog(20'h00100, 8'h0F);
    repeat (PROG_CYC + 3) @(negedge clk);
    rd_check(20'h00100, 8'h0F, "R11 boot writable unlocked");

    do_six(8'h10);
    rd_check(20'h80010, 8'h00, "R7 erase poll");
    do_prog(20'h80040, 8'h00);
    repeat (ERASE_CYC + 5) @(negedge clk);
    rd_check(20'h80010, 8'hFF, "R6 main erased");
    rd_check(20'h00100, 8'hFF, "R6 boot erased unlocked");
    rd_check(20'h80040, 8'hFF, "R8 write while busy ignored");

    do_prog(20'h00100, 8'h0F);
    repeat (PROG_CYC + 3) @(negedge clk);
    do_prog(20'h80100, 8'hA5);
    repeat (PROG_CYC + 3) @(negedge clk);
    rd_check(20'h80300, 8'hA5, "R12 alias");

    do_six(8'h40);
    @(negedge clk); #1 chk("R10 lock set", {7'b0, lock_on}, 8'h01);
    do_prog(20'h00101, 8'h00);
    rd_check(20'h00101, 8'hFF, "R11 locked program dropped");
    do_six(8'h10);
    repeat (ERASE_CYC + 5) @(negedge clk);
    rd_check(20'h00100, 8'h0F, "R11 boot kept on erase");
    rd_check(20'h80100, 8'hFF, "R6 main erased while locked");

    do_six(8'h40);
    @(negedge clk); #1 chk("R10 still locked", {7'b0, lock_on}, 8'h01);
    do_reset();
    @(negedge clk); #1 chk("R10 cleared by reset", {7'b0, lock_on}, 8'h00);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule